// File: doc/BRIEF.md
# Keyed Watchdog Timer with Early-Warning Stage

This block is a watchdog timer that sits on a small 32-bit register bus and counts a slow tick strobe, nominally 32 kHz. Software programs a timeout length, enables the timer, and must keep restarting it with a fixed code word. If software stops doing this, the block raises an active-high reset request. Every register write must carry a key value, so a stray store cannot change the timer. A write without the key has no effect.

In two-stage operation the first expiry does not reset the system. It raises an interrupt and starts the same interval again. Only a second expiry with no restart in between raises the reset request. A separate keyed write can also force a reset request at once.

The reset request is held for a fixed number of ticks. At the end of that time all registers of the block return to their reset values, so the timer comes back disabled.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the mode register reads 0x0000_0000 and the length register reads 0x0000_F800, which is 1984 units (31 s). irq_o and rst_req_o are low.
- R2: A write to offset 0x00 updates the mode register only when bits [31:24] equal 0x22.
  - The stored fields are bit 0 enable, bit 1 output polarity, bit 2 external-reset enable, bit 3 interrupt enable, bit 4 auto start, bit 6 two-stage enable and bit 8 counter select.
  - A read returns these bits and zero everywhere else.
- R3: A write to offset 0x04 updates the length only when bits [4:0] equal 0x08. The length is the field starting at bit 5 and is at least 11 bits wide. A read returns the length at bit 5 and zero in bits [4:0].
- R4: With the enable bit set by a mode write at clock edge E and a length L of at least 1, rst_req_o rises at the edge of tick number L*TICKS_PER_UNIT after E.
- R5: With mode bits 6 and 3 both set, the first expiry raises irq_o and reloads the count. rst_req_o rises only after a further L*TICKS_PER_UNIT ticks with no restart.
- R6: Writing exactly 0x0000_1971 to offset 0x08 reloads the count from the length register and clears irq_o. Any other value written there has no effect.
- R7: Writing exactly 0x0000_1209 to offset 0x14 raises rst_req_o at that edge, whether or not the timer is enabled. Any other value written there has no effect.
- R8: While the enable bit is clear, the count does not run and neither irq_o nor rst_req_o is produced. Setting the enable bit again loads the full length.
- R9: The count advances only on clock edges where tick_i is high.
- R10: rst_req_o stays high for exactly HOLD_TICKS (16) tick edges and then falls. At that edge all registers return to their R1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe from the slow timebase |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_o | output | 1 | Early-warning interrupt |
| rst_req_o | output | 1 | Active-high system reset request |

## Verification
The expiry timing is swept over lengths 1 to 6 in one-stage mode and 2 to 4 in two-stage mode. The rising edge of the reset request is checked one cycle before and at the expected edge, which separates an off-by-one in the prescaler from one in the unit counter.

Keyed writes are paired with near-miss keys (one bit off) at every offset. This shows that the decode compares the whole key field and not a subset. Restart writes are placed mid-count, with both the correct code and a wrong code, so a reload can be told apart from a continued count. Tick gaps and disable/re-enable sequences show that the count truly pauses and that re-enabling restores the full length.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;

   // register byte offsets
   localparam logic [7:0] OFF_MODE  = 8'h00;
   localparam logic [7:0] OFF_LEN   = 8'h04;
   localparam logic [7:0] OFF_KICK  = 8'h08;
   localparam logic [7:0] OFF_SWRST = 8'h14;

   // key and code values
   localparam logic [7:0]  MODE_KEY   = 8'h22;
   localparam logic [4:0]  LEN_KEY    = 5'h08;
   localparam logic [31:0] KICK_CODE  = 32'h0000_1971;
   localparam logic [31:0] SWRST_CODE = 32'h0000_1209;

   // units of the length field per second of a 32 kHz timebase
   localparam int UNITS_PER_SEC = 64;

   typedef struct packed {
      logic cnt_sel;
      logic dual;
      logic auto_st;
      logic irq_en;
      logic ext_en;
      logic ext_pol;
      logic en;
   } mode_t;

endpackage

// File: rtl/keyed_wdog_regs.sv
module keyed_wdog_regs
   import keyed_wdog_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int LEN_W     = 11,
   parameter int RESET_LEN = 1984
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [31:0]       wdata_i,
   input  logic              we_i,
   output logic [31:0]       rdata_o,
   output logic              en_o,
   output logic              dual_o,
   output logic [LEN_W-1:0]  len_o,
   output logic              start_o,
   output logic              kick_o,
   output logic              swrst_o
);

   mode_t            mode_q;
   logic [LEN_W-1:0] len_q;
   logic             hit_mode, hit_len, hit_kick, hit_swrst;
   logic             mode_wr, len_wr;

   assign hit_mode  = addr_i == ADDR_W'(OFF_MODE);
   assign hit_len   = addr_i == ADDR_W'(OFF_LEN);
   assign hit_kick  = addr_i == ADDR_W'(OFF_KICK);
   assign hit_swrst = addr_i == ADDR_W'(OFF_SWRST);

   assign mode_wr = we_i && hit_mode && (wdata_i[31:24] == MODE_KEY);
   assign len_wr  = we_i && hit_len  && (wdata_i[4:0]   == LEN_KEY);
   assign kick_o  = we_i && hit_kick  && (wdata_i == KICK_CODE);
   assign swrst_o = we_i && hit_swrst && (wdata_i == SWRST_CODE);
   assign start_o = mode_wr && wdata_i[0] && !mode_q.en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         len_q  <= LEN_W'(RESET_LEN);
      end else if (clr_i) begin
         mode_q <= '0;
         len_q  <= LEN_W'(RESET_LEN);
      end else begin
         if (mode_wr) begin
            mode_q <= '{cnt_sel: wdata_i[8], dual: wdata_i[6], auto_st: wdata_i[4],
                        irq_en: wdata_i[3], ext_en: wdata_i[2], ext_pol: wdata_i[1],
                        en: wdata_i[0]};
         end
         if (len_wr) begin
            len_q <= wdata_i[5 +: LEN_W];
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      if (hit_mode) begin
         rdata_o = {23'b0, mode_q.cnt_sel, 1'b0, mode_q.dual, 1'b0, mode_q.auto_st,
                    mode_q.irq_en, mode_q.ext_en, mode_q.ext_pol, mode_q.en};
      end else if (hit_len) begin
         rdata_o = {{(27-LEN_W){1'b0}}, len_q, 5'b0};
      end
   end

   assign en_o   = mode_q.en;
   assign dual_o = mode_q.dual && mode_q.irq_en;
   assign len_o  = len_q;

   // R2
   mode_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && hit_mode && wdata_i[31:24] != MODE_KEY && !clr_i) |=> $stable(mode_q));

   // R3
   len_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && hit_len && wdata_i[4:0] != LEN_KEY && !clr_i) |=> $stable(len_q));

endmodule

// File: rtl/keyed_wdog_cnt.sv
module keyed_wdog_cnt #(
   parameter int LEN_W          = 11,
   parameter int TICKS_PER_UNIT = 512
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             tick_i,
   input  logic             en_i,
   input  logic             dual_i,
   input  logic             halt_i,
   input  logic             load_i,
   input  logic [LEN_W-1:0] len_i,
   output logic             irq_o,
   output logic             bite_o
);

   logic             run, unit_end, last, first_stage, stage_q;
   logic [LEN_W-1:0] cnt_q;

   assign run = en_i && !halt_i;

   generate
      if (TICKS_PER_UNIT == 1) begin : g_direct
         assign unit_end = tick_i;
      end else begin : g_pre
         localparam int PRE_W = $clog2(TICKS_PER_UNIT);
         logic [PRE_W-1:0] pre_q;
         logic             wrap;
         assign wrap = pre_q == PRE_W'(TICKS_PER_UNIT - 1);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                pre_q <= '0;
            else if (clr_i || load_i)  pre_q <= '0;
            else if (run && tick_i)    pre_q <= wrap ? '0 : pre_q + 1'b1;
         end
         assign unit_end = tick_i && wrap;
      end
   endgenerate

   assign last        = cnt_q <= LEN_W'(1);
   assign first_stage = dual_i && !stage_q;
   assign bite_o      = run && unit_end && last && !first_stage;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0; stage_q <= 1'b0; irq_o <= 1'b0;
      end else if (clr_i) begin
         cnt_q <= '0; stage_q <= 1'b0; irq_o <= 1'b0;
      end else if (load_i) begin
         cnt_q <= len_i; stage_q <= 1'b0; irq_o <= 1'b0;
      end else if (!en_i) begin
         stage_q <= 1'b0; irq_o <= 1'b0;
      end else if (run && unit_end) begin
         if (!last) begin
            cnt_q <= cnt_q - 1'b1;
         end else if (first_stage) begin
            stage_q <= 1'b1;
            irq_o   <= 1'b1;
            cnt_q   <= len_i;
         end
      end
   end

   // R8
   irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && !load_i) |=> !irq_o);

   // R6
   kick_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> !irq_o);

   // R5
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(en_i && dual_i));

endmodule

// File: rtl/keyed_wdog_hold.sv
module keyed_wdog_hold #(
   parameter int HOLD_TICKS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic trig_i,
   output logic req_o,
   output logic done_o
);

   localparam int CW = $clog2(HOLD_TICKS + 1);

   logic [CW-1:0] left_q;

   assign done_o = req_o && tick_i && (left_q == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_o  <= 1'b0;
         left_q <= '0;
      end else if (!req_o) begin
         if (trig_i) begin
            req_o  <= 1'b1;
            left_q <= CW'(HOLD_TICKS);
         end
      end else if (tick_i) begin
         if (left_q == CW'(1)) begin
            req_o  <= 1'b0;
            left_q <= '0;
         end else begin
            left_q <= left_q - 1'b1;
         end
      end
   end

   // R10
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !done_o) |=> req_o);

   // R7
   trig_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_o && trig_i) |=> req_o);

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
   parameter int ADDR_W         = 8,
   parameter int LEN_W          = 11,
   parameter int TICKS_PER_UNIT = 512,
   parameter int HOLD_TICKS     = 16,
   parameter int RESET_LEN      = 31 * keyed_wdog_pkg::UNITS_PER_SEC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_we,
   output logic [31:0]       bus_rdata,
   output logic              irq_o,
   output logic              rst_req_o
);

   generate
      if (LEN_W < 11 || LEN_W > 27) begin : g_bad_len
         $error("LEN_W must lie in 11..27 so that 31 s fits");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ADDR_W too small for the register offsets");
      end
      if (TICKS_PER_UNIT < 1 || HOLD_TICKS < 1) begin : g_bad_cnt
         $error("TICKS_PER_UNIT and HOLD_TICKS must be positive");
      end
      if (RESET_LEN < 1 || RESET_LEN >= (1 << LEN_W)) begin : g_bad_rlen
         $error("RESET_LEN does not fit the length field");
      end
   endgenerate

   logic             en, dual, start, kick, swrst, bite, clr;
   logic [LEN_W-1:0] len;

   keyed_wdog_regs #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .RESET_LEN(RESET_LEN)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .clr_i(clr),
      .addr_i(bus_addr), .wdata_i(bus_wdata), .we_i(bus_we),
      .rdata_o(bus_rdata), .en_o(en), .dual_o(dual), .len_o(len),
      .start_o(start), .kick_o(kick), .swrst_o(swrst)
   );

   keyed_wdog_cnt #(
      .LEN_W(LEN_W), .TICKS_PER_UNIT(TICKS_PER_UNIT)
   ) cnt_i (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .tick_i(tick_i),
      .en_i(en), .dual_i(dual), .halt_i(rst_req_o),
      .load_i(start || kick), .len_i(len),
      .irq_o(irq_o), .bite_o(bite)
   );

   keyed_wdog_hold #(
      .HOLD_TICKS(HOLD_TICKS)
   ) hold_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .trig_i(bite || swrst), .req_o(rst_req_o), .done_o(clr)
   );

endmodule

// File: tb/keyed_wdog_tb_top.sv
module keyed_wdog_tb_top;

   localparam int TPU  = 2;
   localparam int HOLD = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b1;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        we = 1'b0;
   logic [31:0] rdata;
   logic        irq, rreq;

   int nchk = 0;
   int nbad = 0;

   always #4 clk = ~clk;

   keyed_wdog #(.TICKS_PER_UNIT(TPU), .HOLD_TICKS(HOLD)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick),
      .bus_addr(addr), .bus_wdata(wdata), .bus_we(we),
      .bus_rdata(rdata), .irq_o(irq), .rst_req_o(rreq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(posedge clk);
      #1;
      we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic hold_out(input string tag);
      step(HOLD - 1); chk({tag, " R10 held"}, 32'(rreq), 1);
      step(1);        chk({tag, " R10 fall"}, 32'(rreq), 0);
   endtask

   initial begin
      #(8 * 150000);
      nbad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      rd(8'h00, v); chk("R1 mode", v, 32'h0);
      rd(8'h04, v); chk("R1 len", v, 32'h0000_F800);
      chk("R1 irq", 32'(irq), 0);
      chk("R1 rst", 32'(rreq), 0);

      // R2 field mask and key
      wr(8'h00, 32'h2200_01FE); rd(8'h00, v); chk("R2 mask", v, 32'h0000_015E);
      wr(8'h00, 32'h2200_0000); rd(8'h00, v); chk("R2 clear", v, 32'h0);
      wr(8'h00, 32'h2300_0001); rd(8'h00, v); chk("R2 badkey", v, 32'h0);
      step(40); chk("R2 badkey no rst", 32'(rreq), 0);

      // R3 length key
      wr(8'h04, (32'd5 << 5) | 32'h8); rd(8'h04, v); chk("R3 len", v, 32'h0000_00A0);
      wr(8'h04, (32'd9 << 5) | 32'h9); rd(8'h04, v); chk("R3 badkey", v, 32'h0000_00A0);
      wr(8'h04, (32'd1984 << 5) | 32'h8); rd(8'h04, v); chk("R3 31s", v, 32'h0000_F800);

      // R4 one-stage sweep, R10 hold and clear
      for (int L = 1; L <= 6; L++) begin
         wr(8'h04, (32'(L) << 5) | 32'h8);
         wr(8'h00, 32'h2200_0001);
         step(TPU * L - 1); chk("R4 early", 32'(rreq), 0);
         step(1);           chk("R4 expiry", 32'(rreq), 1);
         chk("R4 no irq", 32'(irq), 0);
         hold_out("R4");
         rd(8'h00, v); chk("R10 mode cleared", v, 32'h0);
         rd(8'h04, v); chk("R10 len cleared", v, 32'h0000_F800);
      end

      // R5 two-stage sweep
      for (int L = 2; L <= 4; L++) begin
         wr(8'h04, (32'(L) << 5) | 32'h8);
         wr(8'h00, 32'h2200_0049);
         step(TPU * L - 1); chk("R5 irq early", 32'(irq), 0);
         step(1);           chk("R5 irq", 32'(irq), 1);
         chk("R5 no rst at irq", 32'(rreq), 0);
         step(TPU * L - 1); chk("R5 rst early", 32'(rreq), 0);
         step(1);           chk("R5 rst", 32'(rreq), 1);
         hold_out("R5");
         chk("R5 irq cleared", 32'(irq), 0);
      end

      // R6 restart mid-count
      wr(8'h04, (32'd4 << 5) | 32'h8);
      wr(8'h00, 32'h2200_0001);
      step(5);
      wr(8'h08, 32'h0000_1971);
      step(TPU * 4 - 1); chk("R6 reload early", 32'(rreq), 0);
      step(1);           chk("R6 reload expiry", 32'(rreq), 1);
      hold_out("R6");

      // R6 wrong restart code
      wr(8'h04, (32'd4 << 5) | 32'h8);
      wr(8'h00, 32'h2200_0001);
      step(3);
      wr(8'h08, 32'h0000_1970);
      step(3); chk("R6 badcode early", 32'(rreq), 0);
      step(1); chk("R6 badcode expiry", 32'(rreq), 1);
      hold_out("R6b");

      // R6 restart clears irq, R8 disable stops count
      wr(8'h04, (32'd3 << 5) | 32'h8);
      wr(8'h00, 32'h2200_0049);
      step(TPU * 3); chk("R6 irq set", 32'(irq), 1);
      wr(8'h08, 32'h0000_1971); chk("R6 irq clr", 32'(irq), 0);
      wr(8'h00, 32'h2200_0048);
      step(40);
      chk("R8 no rst", 32'(rreq), 0);
      chk("R8 no irq", 32'(irq), 0);

      // R8 re-enable loads full length
      wr(8'h04, (32'd3 << 5) | 32'h8);
      wr(8'h00, 32'h2200_0001);
      step(4);
      wr(8'h00, 32'h2200_0000);
      step(30); chk("R8 held", 32'(rreq), 0);
      wr(8'h00, 32'h2200_0001);
      step(TPU * 3 - 1); chk("R8 reload early", 32'(rreq), 0);
      step(1);           chk("R8 reload expiry", 32'(rreq), 1);
      hold_out("R8");

      // R7 software reset
      wr(8'h14, 32'h0000_1208);
      step(2); chk("R7 badcode", 32'(rreq), 0);
      wr(8'h14, 32'h0000_1209); chk("R7 force", 32'(rreq), 1);
      hold_out("R7");

      // R9 tick gating
      tick = 1'b0;
      wr(8'h04, (32'd2 << 5) | 32'h8);
      wr(8'h00, 32'h2200_0001);
      step(30); chk("R9 no tick", 32'(rreq), 0);
      tick = 1'b1;
      step(TPU * 2 - 1); chk("R9 early", 32'(rreq), 0);
      step(1);           chk("R9 expiry", 32'(rreq), 1);
      hold_out("R9");

      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

endmodule